// File: doc/BRIEF.md
# Indirect PCI Configuration and I/O Access Port

This block is a slave on a CPU register bus. It gives the CPU access to PCI configuration space and PCI I/O space through one pointer register and two data windows. Software first stores a target address in the pointer register. It then reads or writes either the configuration window or the I/O window. The block turns each window access into one downstream request, which carries the space, address, size, direction and write data. It waits for the downstream target to accept the request, then returns the read data and completes the CPU access.

Before anything is forwarded, each access is checked against a size and offset legality table. An access that fails the check completes at once with an error flag and produces no downstream traffic. Data in the I/O window is big-endian on the CPU side, so the block swaps the byte lanes within the access size. Data in the configuration window is passed without any swap.

Offsets are 4-bit byte offsets inside the block:
- 0x0 to 0x3: the pointer register.
- 0x4 to 0x7: the configuration window.
- 0x8 to 0xB: the I/O window.
- 0xC to 0xF: unmapped.

The size code on both the CPU side and the downstream side is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for illegal. Downstream data is right-justified in bits [8*n-1:0], with the least significant byte in bits [7:0]. Read data returned to the CPU is zero-extended.

Top module: `pci_ix_port`

## Requirements
- R1: A 4-byte write to offset 0x0 stores the write data in the pointer register with bits [1:0] forced to 0. A 4-byte read of offset 0x0 returns the stored value. Neither access makes a downstream request.
- R2: A pointer-register access with a size other than 4 bytes, or at offsets 0x1 to 0x3, completes with the error flag set and leaves the pointer value unchanged.
- R3: A configuration-window access at offset 0x4+k makes a request with dnSpace=0 and dnAddr = pointer OR k. The request is issued whether bit 31 of the pointer is set or clear.
- R4: An I/O-window access at offset 0x8+k makes a request with dnSpace=1 and dnAddr[15:0] = (pointer[15:0] + k) mod 2^16, with dnAddr[31:16] = 0.
- R5: In the I/O window:
  - k=0 accepts all three sizes.
  - k=2 accepts only 1 or 2 bytes.
  - k=1 and k=3 accept only 1 byte.
  - The configuration window accepts all three sizes at every k.
- R6: An access that the table of R5 rejects completes with the error flag set and makes no downstream request.
- R7: I/O-window data is byte-reversed within the access size in both directions: the 2-byte value 0xABCD travels downstream as 0xCDAB. Configuration-window data passes unswapped. Bytes above the access size read as 0 and are driven as 0 downstream.
- R8: A request holds dnReq and its fields steady until dnReady is seen. The CPU access completes with busReady high for exactly one cycle, in the cycle after the request/ready handshake.
- R9: Size code 3 at any offset, and any access to offsets 0xC to 0xF, completes with the error flag set and makes no request.
- R10: After reset, the pointer reads 0 and dnReq, busReady and busError are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | CPU access request, held until busReady |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | OFF_W | Byte offset inside the block |
| busSize | input | 2 | Access size code |
| busWdata | input | 32 | CPU write data, right-justified |
| busReady | output | 1 | One-cycle completion pulse |
| busError | output | 1 | Error flag, valid with busReady |
| busRdata | output | 32 | Read data, valid with busReady |
| dnReq | output | 1 | Downstream request |
| dnReady | input | 1 | Downstream accept / data return |
| dnSpace | output | 1 | 0 = configuration, 1 = I/O |
| dnAddr | output | 32 | Downstream address |
| dnSize | output | 2 | Downstream size code |
| dnWrite | output | 1 | Downstream direction |
| dnWdata | output | 32 | Downstream write data |
| dnRdata | input | 32 | Downstream read data, sampled with dnReady |

## Verification
The pointer is loaded first with bit 31 set and the low bits dirty, and later with a value near the top of the 16-bit I/O range. The first setting shows that configuration cycles ignore the enable bit and that the low bits are stripped. The second shows that I/O addresses wrap at 16 bits, while configuration addresses would not. Every size is tried at every I/O offset, so each cell of the legality table is hit, and the error cases also confirm that no request escapes to the responder. Reads and writes of both windows use data whose bytes are all distinct, so a missing, extra or misplaced lane swap shows up in the compared value.

// File: rtl/pci_ix_pkg.sv
package pci_ix_pkg;

  localparam int DATA_W = 32;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

  typedef enum logic [1:0] {
    KIND_PTR,
    KIND_CFG,
    KIND_IO,
    KIND_BAD
  } accKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ptrWe;     // store pointer register
    logic rdLocal;   // load read buffer from pointer
    logic rdCapture; // load read buffer from downstream data
    logic ioWin;     // current access targets the I/O window
  } dpStrobe_t;

  function automatic logic [DATA_W-1:0] sizeMask(input logic [1:0] sz);
    case (sz)
      SZ_HALF: return 32'h0000_FFFF;
      SZ_WORD: return 32'hFFFF_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] laneSwap(input logic [DATA_W-1:0] d,
                                                 input logic [1:0] sz);
    logic [DATA_W-1:0] r;
    r = '0;
    case (sz)
      SZ_HALF: r[15:0] = {d[7:0], d[15:8]};
      SZ_WORD: for (int i = 0; i < 4; i++) r[8*i +: 8] = d[8*(3-i) +: 8];
      default: r[7:0] = d[7:0];
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pci_ix_ctrl.sv
module pci_ix_ctrl
  import pci_ix_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [OFF_W-1:0] busAddr,
  input  logic [1:0]       busSize,
  input  logic             dnReady,
  output logic             dnReq,
  output logic             busReady,
  output logic             busError,
  output dpStrobe_t        strobe
);

  localparam int WIN_W = OFF_W - 2;
  localparam logic [WIN_W-1:0] WIN_PTR = WIN_W'(0);
  localparam logic [WIN_W-1:0] WIN_CFG = WIN_W'(1);
  localparam logic [WIN_W-1:0] WIN_IO  = WIN_W'(2);

  typedef enum logic [1:0] {ST_IDLE, ST_FWD, ST_RESP} state_e;

  state_e   stateQ, stateD;
  logic     errQ, errD;
  accKind_e kind;

  logic [WIN_W-1:0] winIdx;
  logic [1:0]       lowOff;

  assign winIdx = busAddr[OFF_W-1:2];
  assign lowOff = busAddr[1:0];

  // legality table
  always_comb begin
    kind = KIND_BAD;
    if (busSize != SZ_BAD) begin
      if (winIdx == WIN_PTR) begin
        if (busSize == SZ_WORD && lowOff == 2'd0) kind = KIND_PTR;
      end else if (winIdx == WIN_CFG) begin
        kind = KIND_CFG;
      end else if (winIdx == WIN_IO) begin
        case (lowOff)
          2'd0:    kind = KIND_IO;
          2'd2:    kind = (busSize != SZ_WORD) ? KIND_IO : KIND_BAD;
          default: kind = (busSize == SZ_BYTE) ? KIND_IO : KIND_BAD;
        endcase
      end
    end
  end

  always_comb begin
    stateD = stateQ;
    errD   = errQ;
    strobe = '0;
    strobe.ioWin = (winIdx == WIN_IO);
    case (stateQ)
      ST_IDLE: begin
        if (busValid) begin
          case (kind)
            KIND_BAD: begin
              errD   = 1'b1;
              stateD = ST_RESP;
            end
            KIND_PTR: begin
              errD           = 1'b0;
              strobe.ptrWe   = busWrite;
              strobe.rdLocal = !busWrite;
              stateD         = ST_RESP;
            end
            default: begin
              errD   = 1'b0;
              stateD = ST_FWD;
            end
          endcase
        end
      end
      ST_FWD: begin
        if (dnReady) begin
          strobe.rdCapture = !busWrite;
          stateD           = ST_RESP;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      errQ   <= errD;
    end
  end

  assign dnReq    = (stateQ == ST_FWD);
  assign busReady = (stateQ == ST_RESP);
  assign busError = busReady && errQ;

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady); // R8

  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busError |-> !$past(dnReq)); // R6

  AST_DONE_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
    (dnReq && dnReady) |=> (busReady && !busError && !dnReq)); // R8

endmodule

// File: rtl/pci_ix_dpath.sv
module pci_ix_dpath
  import pci_ix_pkg::*;
#(
  parameter int OFF_W = 4,
  parameter int IO_AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [OFF_W-1:0]  busAddr,
  input  logic [1:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] dnRdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              dnSpace,
  output logic [DATA_W-1:0] dnAddr,
  output logic [DATA_W-1:0] dnWdata
);

  localparam int PAD_W = DATA_W - IO_AW;

  logic [DATA_W-1:0] ptrQ;
  logic [DATA_W-1:0] rdQ;
  logic [1:0]        lowOff;
  logic [DATA_W-1:0] maskW;
  logic [IO_AW-1:0]  ioSum;

  assign lowOff = busAddr[1:0];
  assign maskW  = sizeMask(busSize);
  assign ioSum  = ptrQ[IO_AW-1:0] + IO_AW'(lowOff);

  assign dnSpace = strobe.ioWin;
  assign dnAddr  = strobe.ioWin ? {{PAD_W{1'b0}}, ioSum}
                                : (ptrQ | {{(DATA_W-2){1'b0}}, lowOff});
  assign dnWdata = strobe.ioWin ? laneSwap(busWdata, busSize)
                                : (busWdata & maskW);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      rdQ  <= '0;
    end else begin
      if (strobe.ptrWe) ptrQ <= {busWdata[DATA_W-1:2], 2'b00};
      if (strobe.rdLocal) rdQ <= ptrQ;
      else if (strobe.rdCapture)
        rdQ <= strobe.ioWin ? laneSwap(dnRdata, busSize) : (dnRdata & maskW);
    end
  end

  assign busRdata = rdQ;

  AST_PTR_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ptrWe |=> (ptrQ[1:0] == 2'b00)); // R1

  AST_PTR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ptrWe |=> $stable(ptrQ)); // R2

endmodule

// File: rtl/pci_ix_port.sv
module pci_ix_port
  import pci_ix_pkg::*;
#(
  parameter int OFF_W = 4,
  parameter int IO_AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [OFF_W-1:0]  busAddr,
  input  logic [1:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  output logic              busReady,
  output logic              busError,
  output logic [DATA_W-1:0] busRdata,
  output logic              dnReq,
  input  logic              dnReady,
  output logic              dnSpace,
  output logic [DATA_W-1:0] dnAddr,
  output logic [1:0]        dnSize,
  output logic              dnWrite,
  output logic [DATA_W-1:0] dnWdata,
  input  logic [DATA_W-1:0] dnRdata
);

  dpStrobe_t strobe;

  pci_ix_ctrl #(.OFF_W(OFF_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .dnReady  (dnReady),
    .dnReq    (dnReq),
    .busReady (busReady),
    .busError (busError),
    .strobe   (strobe)
  );

  pci_ix_dpath #(.OFF_W(OFF_W), .IO_AW(IO_AW)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .busWdata (busWdata),
    .dnRdata  (dnRdata),
    .busRdata (busRdata),
    .dnSpace  (dnSpace),
    .dnAddr   (dnAddr),
    .dnWdata  (dnWdata)
  );

  assign dnSize  = busSize;
  assign dnWrite = busWrite;

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (dnReq && !dnReady) |=> (dnReq && $stable(dnAddr) && $stable(dnSpace)
                             && $stable(dnWdata) && $stable(dnSize))); // R8

  AST_IO_ADDR_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (dnReq && dnSpace) |-> (dnAddr[DATA_W-1:IO_AW] == '0)); // R4

  AST_NO_REQ_BAD_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    dnReq |-> (dnSize != SZ_BAD)); // R9

endmodule

// File: tb/pci_ix_port_tb.sv
module pci_ix_port_tb_top;

  typedef struct {
    string       tag;
    logic        space;
    logic [31:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic [31:0] wdata;
  } reqItem_t;

  typedef struct {
    string       tag;
    logic        chkRd;
    logic        err;
    logic [31:0] rdata;
  } rspItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWdata = '0;
  logic        busReady, busError;
  logic [31:0] busRdata;
  logic        dnReq, dnSpace, dnWrite;
  logic        dnReady = 1'b0;
  logic [31:0] dnAddr, dnWdata;
  logic [31:0] dnRdata = '0;
  logic [1:0]  dnSize;

  int nChecks = 0, nFails = 0;
  reqItem_t reqQ[$];
  rspItem_t rspQ[$];

  always #5 clk = ~clk;

  pci_ix_port dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busReady(busReady), .busError(busError), .busRdata(busRdata),
    .dnReq(dnReq), .dnReady(dnReady), .dnSpace(dnSpace), .dnAddr(dnAddr),
    .dnSize(dnSize), .dnWrite(dnWrite), .dnWdata(dnWdata), .dnRdata(dnRdata)
  );

  function automatic logic [31:0] respData(input logic [31:0] a);
    return 32'hA1B2C3D4 ^ {a[15:0], a[15:0]};
  endfunction

  function automatic logic [31:0] mask(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] rev(input logic [31:0] d, input logic [1:0] s);
    if (s == 2'd0) return {24'h0, d[7:0]};
    if (s == 2'd1) return {16'h0, d[7:0], d[15:8]};
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // responder: accepts after two cycles, compares against expected requests
  initial begin
    int wait_c = 0;
    forever begin
      @(negedge clk);
      if (dnReady) begin
        dnReady = 1'b0;
        check("R8 completion cycle after handshake", {31'b0, busReady}, 32'd1);
      end else if (dnReq) begin
        wait_c++;
        if (wait_c == 2) begin
          wait_c = 0;
          if (reqQ.size() == 0) begin
            check("R6 unexpected downstream request", dnAddr, 32'hxxxx_xxxx);
          end else begin
            reqItem_t e;
            e = reqQ.pop_front();
            check({e.tag, " space"}, {31'b0, dnSpace}, {31'b0, e.space});
            check({e.tag, " addr"}, dnAddr, e.addr);
            check({e.tag, " size/dir"}, {29'b0, dnSize, dnWrite}, {29'b0, e.size, e.wr});
            if (e.wr) check({e.tag, " wdata"}, dnWdata, e.wdata);
          end
          dnRdata = respData(dnAddr);
          dnReady = 1'b1;
        end
      end
    end
  end

  // response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (busReady) begin
        if (rspQ.size() == 0) begin
          check("R8 unexpected completion", 32'd1, 32'd0);
        end else begin
          rspItem_t e;
          e = rspQ.pop_front();
          check({e.tag, " error"}, {31'b0, busError}, {31'b0, e.err});
          if (e.chkRd) check({e.tag, " rdata"}, busRdata, e.rdata);
        end
      end
    end
  end

  task automatic access(input string tag, input logic wr, input logic [3:0] off,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input logic hasReq, input logic space, input logic [31:0] eAddr,
                        input logic [31:0] eWd, input logic eErr, input logic [31:0] eRd);
    reqItem_t q;
    rspItem_t r;
    if (hasReq) begin
      q.tag = tag; q.space = space; q.addr = eAddr; q.size = sz; q.wr = wr; q.wdata = eWd;
      reqQ.push_back(q);
    end
    r.tag = tag; r.err = eErr; r.chkRd = !wr && !eErr;
    r.rdata = (hasReq && !wr)
              ? (space ? rev(respData(eAddr), sz) : (respData(eAddr) & mask(sz)))
              : eRd;
    rspQ.push_back(r);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = off; busSize = sz; busWdata = wd;
    do @(negedge clk); while (!busReady);
    busValid = 1'b0;
  endtask

  task automatic run();
    @(negedge clk);
    check("R10 reset busReady/dnReq/busError", {29'b0, busReady, dnReq, busError}, 32'd0);
    rstN = 1'b1;
    access("R10 pointer after reset", 0, 4'h0, 2'd2, 0, 0, 0, 0, 0, 0, 32'h0);
    access("R1 pointer write", 1, 4'h0, 2'd2, 32'h8000_0A13, 0, 0, 0, 0, 0, 0);
    access("R1 pointer read", 0, 4'h0, 2'd2, 0, 0, 0, 0, 0, 0, 32'h8000_0A10);
    access("R2 pointer half write", 1, 4'h0, 2'd1, 32'h1234, 0, 0, 0, 0, 1, 0);
    access("R2 pointer word at offset 1", 1, 4'h1, 2'd2, 32'h5555_0000, 0, 0, 0, 0, 1, 0);
    access("R2 pointer unchanged", 0, 4'h0, 2'd2, 0, 0, 0, 0, 0, 0, 32'h8000_0A10);
    for (int k = 0; k < 4; k++)
      access("R3 cfg byte read", 0, 4'(4 + k), 2'd0, 0, 1, 0, 32'h8000_0A10 | k, 0, 0, 0);
    access("R3 cfg half read k2", 0, 4'h6, 2'd1, 0, 1, 0, 32'h8000_0A12, 0, 0, 0);
    access("R5 cfg word at k3", 0, 4'h7, 2'd2, 0, 1, 0, 32'h8000_0A13, 0, 0, 0);
    access("R7 cfg word write no swap", 1, 4'h4, 2'd2, 32'hCAFE_BABE, 1, 0,
           32'h8000_0A10, 32'hCAFE_BABE, 0, 0);
    access("R7 cfg byte write masked", 1, 4'h5, 2'd0, 32'hCAFE_BA7E, 1, 0,
           32'h8000_0A11, 32'h0000_007E, 0, 0);
    access("R1 pointer reload", 1, 4'h0, 2'd2, 32'h0001_FFFE, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++)
      access("R4 io byte read wrap", 0, 4'(8 + k), 2'd0, 0, 1, 1,
             {16'h0, 16'hFFFC + 16'(k)}, 0, 0, 0);
    access("R7 io half read swap", 0, 4'hA, 2'd1, 0, 1, 1, 32'h0000_FFFE, 0, 0, 0);
    access("R7 io word read swap", 0, 4'h8, 2'd2, 0, 1, 1, 32'h0000_FFFC, 0, 0, 0);
    access("R7 io word write swap", 1, 4'h8, 2'd2, 32'h1122_3344, 1, 1,
           32'h0000_FFFC, 32'h4433_2211, 0, 0);
    access("R7 io half write swap", 1, 4'hA, 2'd1, 32'h7777_ABCD, 1, 1,
           32'h0000_FFFE, 32'h0000_CDAB, 0, 0);
    access("R5 io half at k0", 1, 4'h8, 2'd1, 32'h0000_0102, 1, 1,
           32'h0000_FFFC, 32'h0000_0201, 0, 0);
    access("R5 R6 io half at k1", 0, 4'h9, 2'd1, 0, 0, 0, 0, 0, 1, 0);
    access("R5 R6 io half at k3", 1, 4'hB, 2'd1, 32'h1, 0, 0, 0, 0, 1, 0);
    access("R5 R6 io word at k2", 0, 4'hA, 2'd2, 0, 0, 0, 0, 0, 1, 0);
    access("R5 R6 io word at k1", 1, 4'h9, 2'd2, 32'h1, 0, 0, 0, 0, 1, 0);
    access("R5 R6 io word at k3", 0, 4'hB, 2'd2, 0, 0, 0, 0, 0, 1, 0);
    access("R9 size code 3 cfg", 0, 4'h4, 2'd3, 0, 0, 0, 0, 0, 1, 0);
    access("R9 size code 3 io", 1, 4'h8, 2'd3, 32'h1, 0, 0, 0, 0, 1, 0);
    access("R9 unmapped offset", 1, 4'hC, 2'd2, 32'h1, 0, 0, 0, 0, 1, 0);
    access("R9 unmapped offset byte", 0, 4'hF, 2'd0, 0, 0, 0, 0, 0, 1, 0);
    access("R2 pointer kept after errors", 0, 4'h0, 2'd2, 0, 0, 0, 0, 0, 0, 32'h0001_FFFC);
    repeat (4) @(negedge clk);
    check("R6 all expected requests seen", reqQ.size(), 0);
    check("R8 all expected completions seen", rspQ.size(), 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule